// File: doc/BRIEF.md
# Loop Iteration Rename Log

While a short loop with a single control path is replayed out of the reorder buffer, its instructions are not written into the reorder buffer again. This block is the small side store that takes their place. For every replayed instruction it keeps the one physical register that rename recorded for it. The entries are arranged as rows, one row per loop iteration, and columns, one column per instruction position in the loop body. Each row has its own count of finished instructions. Write-back events carry the iteration tag that the log handed out at rename time, and each such event bumps the count of the row it names.

Rows retire strictly oldest first. The oldest row may retire once its count covers every instruction the row must complete. Its stored registers then leave one per cycle, in slot order, through a valid/ready release port that feeds the free list. A misprediction reported at a given iteration and slot ends the replay. The mispredicted row is cut short after the branch, and every younger row is marked squashed. The registers of squashed work leave through the same port with a squash flag set, and none of it waits for write-back. Older work finishes and retires normally. When the last row has drained, the log sends a one-cycle clear pulse, which the reorder buffer uses to drop its reuse flags, and then reports itself empty so that a new loop can be admitted.

Top module: `loop_rename_log`

## Requirements
- R1: A start request is taken only while `empty_o` is 1 and the length is in 1..SLOTS. A start with length 0 or greater than SLOTS leaves `empty_o` at 1. A start that arrives while a loop is held is ignored, and the held loop length stays in use.
- R2: Each accepted rename write is stored at the position shown on `ren_tag_o`/`ren_slot_o` in that cycle. The slot counts up from 0 to length−1. The next write then goes to slot 0 of the next row, and rows are used in circular order starting from row 0 after a start.
- R3: `stall_o` is 1 when the next rename write would need a new row and that row is still occupied. While it is 1, rename writes are ignored and the position does not move. It drops once that row has retired.
- R4: A write-back adds one to the count of the row its tag names. It has no effect if that row is free or squashed, or if the count already equals the number of instructions renamed into the row.
- R5: A row releases only when its count reaches its limit (the loop length, or one past the mispredicted slot). Rows release in age order, so a finished younger row waits behind an unfinished older one.
- R6: The release port presents one register per cycle in slot order, slot 0 first. `rel_last_o` marks the final register of a row. While `rel_ready_i` is 0, `rel_valid_o` and `rel_preg_o` hold.
- R7: An accepted misprediction (tag t, slot s) truncates row t to slots 0..s. Slots above s in row t, and every renamed slot of each row younger than t, are released with `rel_squash_o`=1 and need no write-back. From then on, rename writes are ignored.
- R8: Rows that are older than the mispredicted one, and the surviving slots of the mispredicted row, release with `rel_squash_o`=0 after their write-backs, as in normal operation.
- R9: After a misprediction, once the last occupied row has released, `clear_o` is 1 for exactly one cycle and `empty_o` is 1 from the next cycle.
- R10: After reset, `empty_o`=1, `stall_o`=0, `rel_valid_o`=0 and `clear_o`=0.
- R11: A misprediction is ignored when its row is free or squashed, or when its slot is not below the number of instructions renamed into that row. In that case renaming continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin replay of a detected loop |
| start_len_i | input | CNT_W | Instructions per loop iteration |
| ren_valid_i | input | 1 | A replayed instruction was renamed this cycle |
| ren_preg_i | input | PREG_W | Physical register to record for it |
| ren_tag_o | output | TAG_W | Iteration row that the next rename write uses |
| ren_slot_o | output | SLOT_W | Slot that the next rename write uses |
| stall_o | output | 1 | No free row; hold rename |
| wb_valid_i | input | 1 | A replayed instruction finished |
| wb_tag_i | input | TAG_W | Its iteration tag |
| mis_valid_i | input | 1 | Branch misprediction inside the replay |
| mis_tag_i | input | TAG_W | Iteration of the mispredicted branch |
| mis_slot_i | input | SLOT_W | Slot of the mispredicted branch |
| rel_valid_o | output | 1 | A register is offered for release |
| rel_ready_i | input | 1 | Free list accepts it |
| rel_preg_o | output | PREG_W | Register being released |
| rel_squash_o | output | 1 | Register belongs to squashed work |
| rel_last_o | output | 1 | Final register of the current row |
| clear_o | output | 1 | One-cycle pulse: log drained, clear reuse flags |
| empty_o | output | 1 | No loop held; a start may be taken |

## Verification
The hardest state to reach is a misprediction that lands in the middle of a full log while the retire pointer is not at row 0. At that point age order has to be worked out around the wrap, and truncated, squashed and normal rows all have to leave through one port. The bench fills all twelve rows with a two-instruction loop until `stall_o` rises, and retires two rows to move the head. It then reports a misprediction at slot 0 of row 3, so that one row is cut short and eight are squashed with no write-backs at all. A table of loop lengths and iteration counts, including length 1 and the full sixteen slots, then covers truncation at different slots.

// File: rtl/lrl_pkg.sv
`timescale 1ns/1ps
// Shared types for the loop rename log.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lrl_pkg;

    // Replay phase of the log.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_DRAIN = 2'd2
    } lrl_phase_e;

    // Age of a row relative to the retire pointer on a circular buffer.
    function automatic int unsigned lrl_age(input int unsigned row,
                                            input int unsigned head,
                                            input int unsigned rows);
        return (row + rows - head) % rows;
    endfunction

endpackage

// File: rtl/lrl_row.sv
`timescale 1ns/1ps
// One iteration row: occupancy, squash mark, completion limit, number of
// renamed slots and number of finished instructions.
// Assumes alloc_i and retire_i never hit the same row in one cycle
// (alloc needs a free row, retire needs an occupied one).
module lrl_row #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic [CNT_W-1:0] alloc_len_i,
    input  logic             fill_inc_i,
    input  logic             wb_i,
    input  logic             trunc_i,
    input  logic [CNT_W-1:0] trunc_lim_i,
    input  logic             squash_i,
    input  logic             retire_i,
    output logic             occ_o,
    output logic             sq_o,
    output logic [CNT_W-1:0] lim_o,
    output logic [CNT_W-1:0] fill_o,
    output logic             ready_o
);

    logic             occ_q, sq_q;
    logic [CNT_W-1:0] lim_q, fill_q, done_q;

    // Row state update: retire, allocate, or track fill/write-back/recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= 1'b0;
            sq_q   <= 1'b0;
            lim_q  <= '0;
            fill_q <= '0;
            done_q <= '0;
        end else if (retire_i) begin
            occ_q <= 1'b0;
            sq_q  <= 1'b0;
        end else if (alloc_i) begin
            occ_q  <= 1'b1;
            sq_q   <= 1'b0;
            lim_q  <= alloc_len_i;
            fill_q <= CNT_W'(1);
            done_q <= '0;
        end else begin
            if (fill_inc_i)
                fill_q <= fill_q + CNT_W'(1);
            if (wb_i && occ_q && !sq_q && (done_q < fill_q))
                done_q <= done_q + CNT_W'(1);
            if (squash_i)
                sq_q <= 1'b1;
            if (trunc_i && (trunc_lim_i < lim_q))
                lim_q <= trunc_lim_i;
        end
    end

    // Row may retire when squashed, or when all required work is renamed and finished.
    always_comb begin
        ready_o = occ_q && (sq_q || ((done_q >= lim_q) && (fill_q >= lim_q)));
    end

    assign occ_o  = occ_q;
    assign sq_o   = sq_q;
    assign lim_o  = lim_q;
    assign fill_o = fill_q;

    // R4: finished count never exceeds renamed count.
    assert_done_le_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q |-> (done_q <= fill_q));

    // R5: a retired row is free on the next cycle.
    assert_retire_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
        retire_i |=> !occ_q);

endmodule

// File: rtl/lrl_store.sv
`timescale 1ns/1ps
// Register matrix: ITERS rows by SLOTS slots of PREG_W bits.
// One write port (rename), one asynchronous read port (release).
// Contents need no reset: a slot is read only after it was written.
module lrl_store #(
    parameter int ITERS  = 12,
    parameter int SLOTS  = 16,
    parameter int PREG_W = 7,
    parameter int TAG_W  = 4,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [TAG_W-1:0]  wrow_i,
    input  logic [SLOT_W-1:0] wslot_i,
    input  logic [PREG_W-1:0] wdata_i,
    input  logic [TAG_W-1:0]  rrow_i,
    input  logic [SLOT_W-1:0] rslot_i,
    output logic [PREG_W-1:0] rdata_o
);

    logic [PREG_W-1:0] mem_q [ITERS][SLOTS];

    // Record the register of an accepted rename write.
    always_ff @(posedge clk) begin
        if (we_i)
            mem_q[wrow_i][wslot_i] <= wdata_i;
    end

    // Present the register at the release position.
    always_comb begin
        rdata_o = mem_q[rrow_i][rslot_i];
    end

endmodule

// File: rtl/lrl_release.sv
`timescale 1ns/1ps
// Retire engine: walks the oldest row slot by slot through a valid/ready
// port and frees the row after its last renamed slot is accepted.
// Assumes row readiness never drops while the row is presented.
module lrl_release #(
    parameter int ITERS  = 12,
    parameter int TAG_W  = 4,
    parameter int SLOT_W = 4,
    parameter int CNT_W  = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [ITERS-1:0]            row_ready_i,
    input  logic [ITERS-1:0]            row_sq_i,
    input  logic [ITERS-1:0][CNT_W-1:0] row_lim_i,
    input  logic [ITERS-1:0][CNT_W-1:0] row_fill_i,
    input  logic                        rel_ready_i,
    output logic [TAG_W-1:0]            head_o,
    output logic [SLOT_W-1:0]           slot_o,
    output logic                        rel_valid_o,
    output logic                        rel_squash_o,
    output logic                        rel_last_o,
    output logic [ITERS-1:0]            retire_o
);

    logic [TAG_W-1:0]  head_q;
    logic [SLOT_W-1:0] slot_q;
    logic              fire;

    // Offer the current slot of the oldest row and classify it.
    always_comb begin
        rel_valid_o  = row_ready_i[head_q];
        rel_squash_o = row_sq_i[head_q] || (CNT_W'(slot_q) >= row_lim_i[head_q]);
        rel_last_o   = (CNT_W'(slot_q) == (row_fill_i[head_q] - CNT_W'(1)));
        fire         = rel_valid_o && rel_ready_i;
        for (int r = 0; r < ITERS; r++)
            retire_o[r] = fire && rel_last_o && (head_q == TAG_W'(r));
    end

    // Advance slot, and row after the last slot, on each accepted release.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            head_q <= '0;
            slot_q <= '0;
        end else if (fire) begin
            if (rel_last_o) begin
                slot_q <= '0;
                head_q <= (head_q == TAG_W'(ITERS - 1)) ? '0 : head_q + TAG_W'(1);
            end else begin
                slot_q <= slot_q + SLOT_W'(1);
            end
        end
    end

    assign head_o = head_q;
    assign slot_o = slot_q;

    // R5: at most one row retires per cycle.
    assert_one_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(retire_o));

    // R6: an offered register that is not taken stays offered.
    assert_offer_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid_o && !rel_ready_i) |=> rel_valid_o);

endmodule

// File: rtl/loop_rename_log.sv
`timescale 1ns/1ps
// Loop iteration rename log. During loop replay it records one physical
// register per replayed instruction in an iteration-by-slot matrix, counts
// write-backs per iteration, retires iterations in order through a release
// port, and recovers from a misprediction by truncating and squashing rows.
// Assumes SLOTS >= 2 and ITERS >= 2; the replay ends only by misprediction.
module loop_rename_log #(
    parameter int SLOTS  = 16,
    parameter int ITERS  = 12,
    parameter int PREG_W = 7,
    localparam int TAG_W  = $clog2(ITERS),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  start_len_i,
    input  logic              ren_valid_i,
    input  logic [PREG_W-1:0] ren_preg_i,
    output logic [TAG_W-1:0]  ren_tag_o,
    output logic [SLOT_W-1:0] ren_slot_o,
    output logic              stall_o,
    input  logic              wb_valid_i,
    input  logic [TAG_W-1:0]  wb_tag_i,
    input  logic              mis_valid_i,
    input  logic [TAG_W-1:0]  mis_tag_i,
    input  logic [SLOT_W-1:0] mis_slot_i,
    output logic              rel_valid_o,
    input  logic              rel_ready_i,
    output logic [PREG_W-1:0] rel_preg_o,
    output logic              rel_squash_o,
    output logic              rel_last_o,
    output logic              clear_o,
    output logic              empty_o
);

    import lrl_pkg::*;

    lrl_phase_e        phase_q;
    logic [CNT_W-1:0]  len_q;
    logic [TAG_W-1:0]  tail_q;
    logic [CNT_W-1:0]  wslot_q;

    logic [ITERS-1:0]            occ, sq, rdy, alloc, finc, wbh, trn, sqh, ret;
    logic [ITERS-1:0][CNT_W-1:0] lim, fil;
    logic [TAG_W-1:0]            head;
    logic [SLOT_W-1:0]           rslot;
    logic                        start_ok, ren_ok, mis_live, mis_ok, last_slot;
    logic [CNT_W-1:0]            trunc_lim;

    // Accept a start only when idle and the length fits the matrix.
    always_comb begin
        start_ok = start_i && (phase_q == PH_IDLE) &&
                   (start_len_i != '0) && (start_len_i <= CNT_W'(SLOTS));
    end

    // A misprediction counts only on a live row at an already renamed slot.
    always_comb begin
        mis_live = 1'b0;
        for (int r = 0; r < ITERS; r++)
            if (mis_tag_i == TAG_W'(r))
                mis_live = occ[r] && !sq[r] && (CNT_W'(mis_slot_i) < fil[r]);
        mis_ok    = mis_valid_i && (phase_q != PH_IDLE) && mis_live;
        trunc_lim = CNT_W'(mis_slot_i) + CNT_W'(1);
    end

    // Rename position, stall, and acceptance of a rename write.
    always_comb begin
        stall_o    = (phase_q == PH_RUN) && (wslot_q == '0) && occ[tail_q];
        ren_ok     = ren_valid_i && (phase_q == PH_RUN) && !stall_o && !mis_ok;
        last_slot  = (wslot_q == (len_q - CNT_W'(1)));
        ren_tag_o  = tail_q;
        ren_slot_o = wslot_q[SLOT_W-1:0];
        clear_o    = (phase_q == PH_DRAIN) && (occ == '0);
        empty_o    = (phase_q == PH_IDLE);
    end

    // Decode per-row events from rename, write-back and misprediction.
    always_comb begin
        for (int r = 0; r < ITERS; r++) begin
            alloc[r] = ren_ok && (wslot_q == '0) && (tail_q == TAG_W'(r));
            finc[r]  = ren_ok && (wslot_q != '0) && (tail_q == TAG_W'(r));
            wbh[r]   = wb_valid_i && (wb_tag_i == TAG_W'(r));
            trn[r]   = mis_ok && (mis_tag_i == TAG_W'(r));
            sqh[r]   = mis_ok && occ[r] &&
                       (lrl_age(r, int'(head), ITERS) >
                        lrl_age(int'(mis_tag_i), int'(head), ITERS));
        end
    end

    // Replay phase, held loop length and rename position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            len_q   <= '0;
            tail_q  <= '0;
            wslot_q <= '0;
        end else begin
            if (start_ok) begin
                phase_q <= PH_RUN;
                len_q   <= start_len_i;
                tail_q  <= '0;
                wslot_q <= '0;
            end else if (mis_ok) begin
                phase_q <= PH_DRAIN;
            end else if (clear_o) begin
                phase_q <= PH_IDLE;
            end
            if (ren_ok) begin
                if (last_slot) begin
                    wslot_q <= '0;
                    tail_q  <= (tail_q == TAG_W'(ITERS - 1)) ? '0 : tail_q + TAG_W'(1);
                end else begin
                    wslot_q <= wslot_q + CNT_W'(1);
                end
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < ITERS; g++) begin : g_row
            lrl_row #(.CNT_W(CNT_W)) u_row (
                .clk        (clk),
                .rst_n      (rst_n),
                .alloc_i    (alloc[g]),
                .alloc_len_i(len_q),
                .fill_inc_i (finc[g]),
                .wb_i       (wbh[g]),
                .trunc_i    (trn[g]),
                .trunc_lim_i(trunc_lim),
                .squash_i   (sqh[g]),
                .retire_i   (ret[g]),
                .occ_o      (occ[g]),
                .sq_o       (sq[g]),
                .lim_o      (lim[g]),
                .fill_o     (fil[g]),
                .ready_o    (rdy[g])
            );
        end
    endgenerate

    lrl_store #(
        .ITERS(ITERS), .SLOTS(SLOTS), .PREG_W(PREG_W),
        .TAG_W(TAG_W), .SLOT_W(SLOT_W)
    ) u_store (
        .clk    (clk),
        .we_i   (ren_ok),
        .wrow_i (tail_q),
        .wslot_i(wslot_q[SLOT_W-1:0]),
        .wdata_i(ren_preg_i),
        .rrow_i (head),
        .rslot_i(rslot),
        .rdata_o(rel_preg_o)
    );

    lrl_release #(
        .ITERS(ITERS), .TAG_W(TAG_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
    ) u_rel (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_ok),
        .row_ready_i (rdy),
        .row_sq_i    (sq),
        .row_lim_i   (lim),
        .row_fill_i  (fil),
        .rel_ready_i (rel_ready_i),
        .head_o      (head),
        .slot_o      (rslot),
        .rel_valid_o (rel_valid_o),
        .rel_squash_o(rel_squash_o),
        .rel_last_o  (rel_last_o),
        .retire_o    (ret)
    );

    // R1: an out-of-range start leaves the log empty.
    assert_bad_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && start_i && ((start_len_i == '0) || (start_len_i > CNT_W'(SLOTS))))
        |=> empty_o);

    // R2: the rename slot stays inside the held loop length.
    assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_o |-> (wslot_q < len_q));

    // R3: a stalled rename write does not move the position.
    assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !start_i) |=> ((ren_tag_o == $past(ren_tag_o)) &&
                                   (ren_slot_o == $past(ren_slot_o))));

    // R6: an offered register stays the same until taken.
    assert_preg_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid_o && !rel_ready_i) |=> $stable(rel_preg_o));

    // R9: the clear pulse lasts one cycle and is followed by empty.
    assert_clear_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> (!clear_o && empty_o));

endmodule

// File: tb/tb_loop_rename_log.sv
`timescale 1ns/1ps
// Bench for loop_rename_log: a table of loop shapes walked by one loop,
// then directed tests for reset, bad starts, stall, ordering, hold and recovery.
module tb_loop_rename_log;

    localparam int SLOTS  = 16;
    localparam int ITERS  = 12;
    localparam int PREG_W = 7;
    localparam int TAG_W  = $clog2(ITERS);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CNT_W  = $clog2(SLOTS + 1);

    // Each row: loop length, iterations renamed, mispredicted slot in the last row.
    localparam int NVEC = 5;
    localparam int VEC [NVEC][3] = '{
        '{4, 3, 3}, '{1, 12, 0}, '{16, 2, 5}, '{7, 5, 0}, '{3, 12, 1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CNT_W-1:0]  start_len_i = '0;
    logic              ren_valid_i = 1'b0;
    logic [PREG_W-1:0] ren_preg_i = '0;
    logic [TAG_W-1:0]  ren_tag_o;
    logic [SLOT_W-1:0] ren_slot_o;
    logic              stall_o;
    logic              wb_valid_i = 1'b0;
    logic [TAG_W-1:0]  wb_tag_i = '0;
    logic              mis_valid_i = 1'b0;
    logic [TAG_W-1:0]  mis_tag_i = '0;
    logic [SLOT_W-1:0] mis_slot_i = '0;
    logic              rel_valid_o;
    logic              rel_ready_i = 1'b0;
    logic [PREG_W-1:0] rel_preg_o;
    logic              rel_squash_o;
    logic              rel_last_o;
    logic              clear_o;
    logic              empty_o;

    int nchk = 0;
    int nerr = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    loop_rename_log #(.SLOTS(SLOTS), .ITERS(ITERS), .PREG_W(PREG_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .start_len_i(start_len_i),
        .ren_valid_i(ren_valid_i), .ren_preg_i(ren_preg_i),
        .ren_tag_o(ren_tag_o), .ren_slot_o(ren_slot_o), .stall_o(stall_o),
        .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i),
        .mis_valid_i(mis_valid_i), .mis_tag_i(mis_tag_i), .mis_slot_i(mis_slot_i),
        .rel_valid_o(rel_valid_o), .rel_ready_i(rel_ready_i),
        .rel_preg_o(rel_preg_o), .rel_squash_o(rel_squash_o),
        .rel_last_o(rel_last_o), .clear_o(clear_o), .empty_o(empty_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [PREG_W-1:0] pg(input int it, input int s);
        return PREG_W'((it * 16 + s) * 5 + 1);
    endfunction

    // Offer-check one release and let it be taken on the next edge.
    task automatic expect_rel(input string req, input int preg, input int sqf, input int last);
        #1;
        chk({req, " rel_valid"}, int'(rel_valid_o), 1);
        chk({req, " rel_preg"}, int'(rel_preg_o), preg);
        chk({req, " rel_squash"}, int'(rel_squash_o), sqf);
        chk({req, " rel_last"}, int'(rel_last_o), last);
        step();
    endtask

    // One table entry: fill, finish, mispredict in last row, drain.
    task automatic run_loop(input int len, input int iters, input int ms);
        start_i = 1'b1; start_len_i = CNT_W'(len);
        step();
        start_i = 1'b0;
        for (int it = 0; it < iters; it++)
            for (int s = 0; s < len; s++) begin
                ren_valid_i = 1'b1; ren_preg_i = pg(it, s);
                #1;
                chk("R2 ren_tag", int'(ren_tag_o), it);
                chk("R2 ren_slot", int'(ren_slot_o), s);
                step();
            end
        ren_valid_i = 1'b0;
        for (int it = 0; it < iters; it++)
            for (int s = 0; s < len; s++) begin
                wb_valid_i = 1'b1; wb_tag_i = TAG_W'(it);
                step();
            end
        wb_valid_i = 1'b0;
        mis_valid_i = 1'b1; mis_tag_i = TAG_W'(iters - 1); mis_slot_i = SLOT_W'(ms);
        step();
        mis_valid_i = 1'b0;
        rel_ready_i = 1'b1;
        for (int it = 0; it < iters; it++)
            for (int s = 0; s < len; s++)
                expect_rel((it == iters - 1 && s > ms) ? "R7" : "R8 R5 R6", int'(pg(it, s)),
                           (it == iters - 1 && s > ms) ? 1 : 0, (s == len - 1) ? 1 : 0);
        rel_ready_i = 1'b0;
        #1;
        chk("R9 clear pulse", int'(clear_o), 1);
        step();
        #1;
        chk("R9 empty after clear", int'(empty_o), 1);
        chk("R9 clear one cycle", int'(clear_o), 0);
        step();
    endtask

    task automatic finish_sim();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R10: reset state
        #1;
        chk("R10 empty", int'(empty_o), 1);
        chk("R10 stall", int'(stall_o), 0);
        chk("R10 rel_valid", int'(rel_valid_o), 0);
        chk("R10 clear", int'(clear_o), 0);

        // Table of loop shapes
        for (int i = 0; i < NVEC; i++)
            run_loop(VEC[i][0], VEC[i][1], VEC[i][2]);

        // R1: out-of-range lengths are refused
        start_i = 1'b1; start_len_i = '0;
        step();
        #1; chk("R1 len 0 refused", int'(empty_o), 1);
        start_len_i = CNT_W'(17);
        step();
        #1; chk("R1 len 17 refused", int'(empty_o), 1);

        // R1: start while busy keeps the held length
        start_len_i = CNT_W'(2);
        step();
        #1; chk("R1 start taken", int'(empty_o), 0);
        start_len_i = CNT_W'(5);
        step();
        start_i = 1'b0;
        ren_valid_i = 1'b1; ren_preg_i = 7'd10;
        step();
        ren_valid_i = 1'b0;

        // R11: slot not yet renamed, then free row: both ignored
        mis_valid_i = 1'b1; mis_tag_i = 4'd0; mis_slot_i = 4'd1;
        step();
        mis_tag_i = 4'd5; mis_slot_i = 4'd0;
        step();
        mis_valid_i = 1'b0;
        ren_valid_i = 1'b1; ren_preg_i = 7'd11;
        #1;
        chk("R11 position tag", int'(ren_tag_o), 0);
        chk("R11 position slot", int'(ren_slot_o), 1);
        step();
        #1;
        chk("R11 rename still accepted", int'(ren_slot_o), 0);
        chk("R1 held length 2 wraps to row 1", int'(ren_tag_o), 1);
        for (int k = 2; k < 24; k++) begin
            ren_preg_i = PREG_W'(10 + k);
            step();
        end
        ren_valid_i = 1'b0;

        // R3: all rows occupied
        #1;
        chk("R3 stall raised", int'(stall_o), 1);
        ren_valid_i = 1'b1; ren_preg_i = 7'd99;
        step();
        ren_valid_i = 1'b0;
        #1;
        chk("R3 stalled tag", int'(ren_tag_o), 0);
        chk("R3 stalled slot", int'(ren_slot_o), 0);
        chk("R3 stall held", int'(stall_o), 1);

        // R5/R8: younger row done first must wait; R4 write-backs
        wb_valid_i = 1'b1; wb_tag_i = 4'd1;
        step(); step();
        wb_tag_i = 4'd0;
        rel_ready_i = 1'b1;
        step();
        wb_valid_i = 1'b0;
        #1;
        chk("R5 row 1 waits for row 0", int'(rel_valid_o), 0);
        rel_ready_i = 1'b0;
        wb_valid_i = 1'b1;
        step();
        wb_valid_i = 1'b0;
        #1;
        chk("R4 row 0 ready after second write-back", int'(rel_valid_o), 1);

        // R6: hold while not ready
        for (int h = 0; h < 3; h++) begin
            step();
            #1;
            chk("R6 hold valid", int'(rel_valid_o), 1);
            chk("R6 hold preg", int'(rel_preg_o), 10);
        end
        rel_ready_i = 1'b1;
        expect_rel("R6 row0 s0", 10, 0, 0);
        expect_rel("R6 row0 s1", 11, 0, 1);
        expect_rel("R5 row1 s0", 12, 0, 0);
        expect_rel("R5 row1 s1", 13, 0, 1);
        rel_ready_i = 1'b0;
        #1;
        chk("R3 stall released", int'(stall_o), 0);
        chk("R5 row 2 not done", int'(rel_valid_o), 0);

        // R7: mispredict at row 3 slot 0 with head at row 2
        mis_valid_i = 1'b1; mis_tag_i = 4'd3; mis_slot_i = 4'd0;
        step();
        mis_valid_i = 1'b0;
        wb_valid_i = 1'b1; wb_tag_i = 4'd2;
        step(); step();
        wb_tag_i = 4'd3;
        step();
        wb_tag_i = 4'd7;
        step();
        wb_valid_i = 1'b0;
        ren_valid_i = 1'b1; ren_preg_i = 7'd100;
        step();
        ren_valid_i = 1'b0;
        rel_ready_i = 1'b1;
        for (int r = 2; r < 12; r++)
            for (int s = 0; s < 2; s++)
                expect_rel((r == 3 && s == 1) || r > 3 ? "R7" : "R8",
                           10 + 2 * r + s, ((r == 3 && s == 1) || r > 3) ? 1 : 0,
                           (s == 1) ? 1 : 0);
        rel_ready_i = 1'b0;
        #1;
        chk("R9 clear after recovery", int'(clear_o), 1);
        step();
        #1;
        chk("R9 empty after recovery", int'(empty_o), 1);
        chk("R9 no release left", int'(rel_valid_o), 0);
        step();
        finish_sim();
    end

endmodule